// File: doc/BRIEF.md
# Uplink Link Synchronization Controller

This block sits on the uplink side of a serial link, between the symbol detector on the receive path and the symbol encoder on the transmit path. It looks at the class of each received downlink symbol and picks the class of symbol that the uplink transmits. Its job is to take the link from idle to a synchronized state, and then hand it over to normal frame traffic. The class values cover start and end markers, which travel uncoded, the two comma characters K28.5 and K28.1, and frames.

Two bring-up variants exist. The full variant starts when the downlink sends start markers. The uplink answers that phase with K28.5. Both sides then move to K28.1, and the sequence closes with end markers. The short variant begins directly with K28.1 from the downlink, which the uplink answers with end markers. Every phase advances only after a run of consecutive expected symbols, and the run length can be set. Once the link is synchronized, the uplink sends frames and inserts a K28.5 monitoring character at a fixed period. A wrong symbol or a phase that lasts too long drops the link back to idle and raises an error flag.

Top module: `link_sync_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: `tx_sel` = 0 (fill), `link_up` = 0 and `sync_err` = 0.
- R2: Received classes on `rx_sym`, valid with `rx_valid`, are 0 start marker, 1 end marker, 2 K28.5, 3 K28.1 and 4 frame; 5 to 7 are unexpected. A start marker begins the full procedure, and `tx_sel` = 1 (K28.5) holds until the run of consecutive start markers reaches the threshold. The first start marker counts toward that run.
- R3: In the full procedure, a run of K28.1 moves `tx_sel` from 2 (K28.1) to 3 (end marker). A later run of end markers enters data exchange, with `tx_sel` = 4 (frame) and `link_up` = 1.
- R4: In idle, a received K28.1 starts the short procedure and counts as its first symbol. `tx_sel` = 3 (end marker) holds until the K28.1 run reaches the threshold, and then data exchange begins.
- R5: The run threshold is `cfg_run_len`, and the value 0 selects the default of 4. In the end-marker phase a K28.1 restarts the run without error.
- R6: A start marker in any state other than the start-marker phase restarts the full procedure and clears `sync_err`.
- R7: Any other class that is not expected in a synchronization phase sets `sync_err` = 1 and returns the controller to idle (`tx_sel` = 0).
- R8: A synchronization phase that lasts `TIMEOUT_CYC` cycles sets `sync_err` and returns the controller to idle.
- R9: In data exchange, `tx_sel` is 1 (K28.5) for one cycle in every `BEACON_PERIOD` cycles. The first K28.5 comes `BEACON_PERIOD`-1 cycles after entry, and `tx_sel` is 4 at all other times.
- R10: `link_up` is 1 only in data exchange, and received classes other than the start marker do not change that state.
- R11: In idle, classes other than the start marker and K28.1 are ignored, and `sync_err` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received symbol class is present |
| rx_sym | input | 3 | Received downlink symbol class |
| cfg_run_len | input | RUN_W (4) | Consecutive-symbol threshold, 0 selects the default |
| tx_sel | output | 3 | Uplink symbol class to transmit |
| link_up | output | 1 | Link is in data exchange |
| sync_err | output | 1 | Last synchronization attempt failed |

## Verification
The bench builds the controller with `TIMEOUT_CYC` = 20 and `BEACON_PERIOD` = 8. These values let the run reach the phase timeout and see two monitoring characters, both within a few dozen cycles. The run threshold stays a port, so the bench switches between the default of 4 and the values 1, 2 and 3. This covers single-symbol phases, the short procedure finishing in one symbol, and the run restart in the end-marker phase.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    RX_START = 3'd0,
    RX_END   = 3'd1,
    RX_KA    = 3'd2,
    RX_KB    = 3'd3,
    RX_FRAME = 3'd4
  } rx_cls_e;

  typedef enum logic [2:0] {
    TX_FILL  = 3'd0,
    TX_KA    = 3'd1,
    TX_KB    = 3'd2,
    TX_END   = 3'd3,
    TX_FRAME = 3'd4
  } tx_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_KB    = 3'd2,
    ST_END   = 3'd3,
    ST_QUICK = 3'd4,
    ST_DATA  = 3'd5
  } phase_e;
endpackage

// File: rtl/lsc_run_counter.sv
module lsc_run_counter #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             clear,
  input  logic             hit,
  input  logic [RUN_W-1:0] thr,
  output logic             reached
);
  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W:0]   plus;

  always_comb begin
    plus    = (restart ? {(RUN_W+1){1'b0}} : {1'b0, cnt_q}) + (RUN_W+1)'(1);
    reached = (hit || restart) && (plus >= {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= RUN_W'(1);
    else if (clear)   cnt_q <= '0;
    else if (hit && !plus[RUN_W]) cnt_q <= plus[RUN_W-1:0];
  end
endmodule

// File: rtl/lsc_phase_timer.sv
module lsc_phase_timer #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/lsc_tx_select.sv
module lsc_tx_select
  import lsc_pkg::*;
#(
  parameter int BEACON_PERIOD = 64
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_q,
  input  phase_e phase_n,
  output logic [2:0] tx_sel
);
  localparam int MW = (BEACON_PERIOD > 1) ? $clog2(BEACON_PERIOD) : 1;
  localparam logic [MW-1:0] LAST = MW'(BEACON_PERIOD - 1);

  logic [MW-1:0] mon_q, mon_n;
  tx_cls_e       tx_n;

  always_comb begin
    if (phase_n == ST_DATA && phase_q == ST_DATA)
      mon_n = (mon_q == LAST) ? '0 : mon_q + MW'(1);
    else
      mon_n = '0;
    case (phase_n)
      ST_START: tx_n = TX_KA;
      ST_KB:    tx_n = TX_KB;
      ST_END:   tx_n = TX_END;
      ST_QUICK: tx_n = TX_END;
      ST_DATA:  tx_n = (mon_n == LAST) ? TX_KA : TX_FRAME;
      default:  tx_n = TX_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_q  <= '0;
      tx_sel <= TX_FILL;
    end else begin
      mon_q  <= mon_n;
      tx_sel <= tx_n;
    end
  end
endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
  import lsc_pkg::*;
#(
  parameter int RUN_W         = 4,
  parameter int DEFAULT_RUN   = 4,
  parameter int TIMEOUT_CYC   = 1024,
  parameter int BEACON_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [2:0]       rx_sym,
  input  logic [RUN_W-1:0] cfg_run_len,
  output logic [2:0]       tx_sel,
  output logic             link_up,
  output logic             sync_err
);
  phase_e           phase_q, phase_n;
  logic             err_n;
  logic [RUN_W-1:0] thr;
  logic             is_start, in_sync;
  logic             ctr_restart, ctr_hit, ctr_clear, reached;
  logic             tmr_clear, expired;

  assign thr      = (cfg_run_len == '0) ? RUN_W'(DEFAULT_RUN) : cfg_run_len;
  assign is_start = rx_valid && (rx_sym == RX_START);
  assign in_sync  = (phase_q == ST_START) || (phase_q == ST_KB) ||
                    (phase_q == ST_END)   || (phase_q == ST_QUICK);

  always_comb begin
    ctr_restart = rx_valid &&
                  ((rx_sym == RX_START && phase_q != ST_START) ||
                   (rx_sym == RX_KB && phase_q == ST_IDLE));
    ctr_hit = rx_valid &&
              ((phase_q == ST_START && rx_sym == RX_START) ||
               (phase_q == ST_KB    && rx_sym == RX_KB)    ||
               (phase_q == ST_END   && rx_sym == RX_END)   ||
               (phase_q == ST_QUICK && rx_sym == RX_KB));
  end

  lsc_run_counter #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst(rst), .restart(ctr_restart), .clear(ctr_clear),
    .hit(ctr_hit), .thr(thr), .reached(reached)
  );

  lsc_phase_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clear(tmr_clear), .run(in_sync), .expired(expired)
  );

  always_comb begin
    logic fault;
    logic run_reset;
    fault     = 1'b0;
    run_reset = 1'b0;
    phase_n   = phase_q;
    err_n     = sync_err;
    if (is_start) begin
      if (phase_q == ST_START) begin
        if (reached) phase_n = ST_KB;
      end else begin
        phase_n = reached ? ST_KB : ST_START;
        err_n   = 1'b0;
      end
    end else if (expired) begin
      fault = 1'b1;
    end else if (rx_valid) begin
      case (phase_q)
        ST_IDLE: begin
          if (rx_sym == RX_KB) begin
            phase_n = reached ? ST_DATA : ST_QUICK;
            err_n   = 1'b0;
          end
        end
        ST_START: fault = 1'b1;
        ST_KB: begin
          if (rx_sym == RX_KB) begin
            if (reached) phase_n = ST_END;
          end else fault = 1'b1;
        end
        ST_END: begin
          if (rx_sym == RX_END) begin
            if (reached) phase_n = ST_DATA;
          end else if (rx_sym == RX_KB) run_reset = 1'b1;
          else fault = 1'b1;
        end
        ST_QUICK: begin
          if (rx_sym == RX_KB) begin
            if (reached) phase_n = ST_DATA;
          end else fault = 1'b1;
        end
        default: ;
      endcase
    end
    if (fault) begin
      phase_n = ST_IDLE;
      err_n   = 1'b1;
    end
    ctr_clear = run_reset || (phase_n != phase_q);
    tmr_clear = (phase_n != phase_q) || ctr_restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= ST_IDLE;
      sync_err <= 1'b0;
      link_up  <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      sync_err <= err_n;
      link_up  <= (phase_n == ST_DATA);
    end
  end

  lsc_tx_select #(.BEACON_PERIOD(BEACON_PERIOD)) u_tx (
    .clk(clk), .rst(rst), .phase_q(phase_q), .phase_n(phase_n), .tx_sel(tx_sel)
  );

  // R6: a start marker always leads to a comma phase with the error cleared
  p_start_restart_r6: assert property (@(posedge clk) disable iff (rst)
    is_start |=> ((tx_sel == TX_KA || tx_sel == TX_KB) && !sync_err && !link_up));

  // R7: a new error always coincides with idle output
  p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_err) |-> (tx_sel == TX_FILL && !link_up));

  // R8: timer expiry without a start marker ends in idle with error
  p_timeout_r8: assert property (@(posedge clk) disable iff (rst)
    (expired && !is_start) |=> (sync_err && tx_sel == TX_FILL));

  // R10: ready only while frames or monitoring commas go out
  p_ready_data_r10: assert property (@(posedge clk) disable iff (rst)
    link_up |-> (tx_sel == TX_FRAME || tx_sel == TX_KA));

  generate
    if (BEACON_PERIOD > 1) begin : g_beacon_chk
      // R9: the monitoring comma lasts exactly one cycle
      p_beacon_single_r9: assert property (@(posedge clk) disable iff (rst)
        (link_up && tx_sel == TX_KA) |=> !(link_up && tx_sel == TX_KA));
    end
  endgenerate
endmodule

// File: tb/link_sync_ctrl_tb.sv
module link_sync_ctrl_tb;
  localparam int RUN_W = 4;
  localparam logic [2:0] S_START = 3'd0, S_END = 3'd1, S_KA = 3'd2, S_KB = 3'd3, S_FRM = 3'd4;
  localparam logic [2:0] T_FILL = 3'd0, T_KA = 3'd1, T_KB = 3'd2, T_END = 3'd3, T_FRM = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [2:0] rx_sym = 3'd0;
  logic [RUN_W-1:0] cfg_run_len = '0;
  logic [2:0] tx_sel;
  logic link_up, sync_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] tx;
    bit up;
    bit err;
    string req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  link_sync_ctrl #(.RUN_W(RUN_W), .DEFAULT_RUN(4), .TIMEOUT_CYC(20), .BEACON_PERIOD(8)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sym(rx_sym),
    .cfg_run_len(cfg_run_len), .tx_sel(tx_sel), .link_up(link_up), .sync_err(sync_err)
  );

  task automatic compare(input logic [2:0] etx, input bit eup, input bit eerr, input string req);
    n_chk++;
    if (tx_sel !== etx || link_up !== eup || sync_err !== eerr) begin
      n_bad++;
      $display("FAIL %s: tx=%0d up=%0d err=%0d expected tx=%0d up=%0d err=%0d",
               req, tx_sel, link_up, sync_err, etx, eup, eerr);
    end
  endtask

  // monitor: pops one expected item per clock edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.tx, e.up, e.err, e.req);
    end
  end

  task automatic drive(input bit v, input logic [2:0] s, input logic [2:0] etx,
                       input bit eup, input bit eerr, input string req);
    exp_t e;
    @(negedge clk);
    rx_valid = v;
    rx_sym   = s;
    e.tx = etx; e.up = eup; e.err = eerr; e.req = req;
    sb.push_back(e);
  endtask

  task automatic many(input int n, input bit v, input logic [2:0] s, input logic [2:0] etx,
                      input bit eup, input bit eerr, input string req);
    for (int i = 0; i < n; i++) drive(v, s, etx, eup, eerr, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(T_FILL, 1'b0, 1'b0, "R1 in reset");
    rst = 1'b0;
    drive(0, S_START, T_FILL, 0, 0, "R1");

    // full procedure with default threshold (cfg 0 -> 4)
    cfg_run_len = 4'd0;
    many(3, 1, S_START, T_KA, 0, 0, "R2 R5");
    drive(1, S_START, T_KB, 0, 0, "R2 R5");
    many(3, 1, S_KB, T_KB, 0, 0, "R3");
    drive(1, S_KB, T_END, 0, 0, "R3");
    many(3, 1, S_END, T_END, 0, 0, "R3");
    drive(1, S_END, T_FRM, 1, 0, "R3");

    // data exchange: beacon period 8, other classes ignored
    for (int i = 1; i <= 16; i++) begin
      logic [2:0] s;
      s = (i % 4 == 0) ? S_FRM : (i % 4 == 1) ? S_END : (i % 4 == 2) ? S_KA : S_KB;
      if (i == 5) s = 3'd6;
      drive(1, s, (i % 8 == 7) ? T_KA : T_FRM, 1, 0, "R9 R10");
    end

    // restart from data, then unexpected class in start phase
    drive(1, S_START, T_KA, 0, 0, "R6");
    drive(1, S_FRM, T_FILL, 0, 1, "R7");

    // idle ignores other classes, error kept
    drive(1, S_END, T_FILL, 0, 1, "R11");
    drive(1, S_KA, T_FILL, 0, 1, "R11");
    drive(1, S_FRM, T_FILL, 0, 1, "R11");
    drive(1, 3'd7, T_FILL, 0, 1, "R11");

    // short procedure, threshold 2
    cfg_run_len = 4'd2;
    drive(1, S_KB, T_END, 0, 0, "R4");
    drive(1, S_KB, T_FRM, 1, 0, "R4");

    // timeout in start phase
    drive(1, S_START, T_KA, 0, 0, "R6");
    many(19, 0, S_START, T_KA, 0, 0, "R8");
    drive(0, S_START, T_FILL, 0, 1, "R8");

    // threshold 3 with run restart in end-marker phase
    cfg_run_len = 4'd3;
    many(2, 1, S_START, T_KA, 0, 0, "R5");
    drive(1, S_START, T_KB, 0, 0, "R5");
    many(2, 1, S_KB, T_KB, 0, 0, "R5");
    drive(1, S_KB, T_END, 0, 0, "R5");
    many(2, 1, S_END, T_END, 0, 0, "R5");
    drive(1, S_KB, T_END, 0, 0, "R5");
    many(2, 1, S_END, T_END, 0, 0, "R5");
    drive(1, S_END, T_FRM, 1, 0, "R5");

    // threshold 1: one start marker reaches the K28.1 phase
    cfg_run_len = 4'd1;
    drive(1, S_START, T_KB, 0, 0, "R5 R6");
    drive(1, S_KA, T_FILL, 0, 1, "R7");
    drive(1, S_KB, T_FRM, 1, 0, "R4");
    drive(1, S_START, T_KB, 0, 0, "R6");
    drive(1, S_KB, T_END, 0, 0, "R3");
    drive(1, S_FRM, T_FILL, 0, 1, "R7");

    // restart from the K28.1 phase
    cfg_run_len = 4'd2;
    drive(1, S_START, T_KA, 0, 0, "R6");
    drive(1, S_START, T_KB, 0, 0, "R2");
    drive(1, S_START, T_KA, 0, 0, "R6");
    drive(0, S_START, T_KA, 0, 0, "R6");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule